// File: doc/BRIEF.md
# Master-Clock Ratio Bit-Clock Detector

This block sits on the receive side of a stereo serial audio link. It runs on the master clock and watches the word-select (LRCK) and serial bit-clock (SCK) lines that arrive from outside. It measures how many master-clock cycles fit into one word-select period. When no bit clock is supplied, it derives one from that measurement.

SCK activity places the block in external mode. In that mode the bit-clock enable follows the rising edges of the synchronised SCK, which is when data is valid. After two complete, consecutive SCK-free frames that both measure the same supported ratio, the block locks and enters internal mode. In internal mode it reports the bit-clock multiple of the sample rate and the widest data word that multiple carries. It also generates a one-cycle bit-clock enable at the matching rate, realigned at every word-select rising edge.

The reset input is expected to be released in step with the master clock. Word data recovery is left to a downstream deserialiser that uses `bclk_en` as its shift strobe.

Top module: `bclk_ratio_detect`

## Requirements
- R1: While reset is low and right after it, `locked`, `ext_mode` and `bclk_en` are 0, `sck_mult` is 0 (none) and `max_width` is 0.
- R2: Both inputs pass through a two-stage synchroniser. A frame is the span between two synchronised LRCK rising edges. The first rising edge after reset only opens a frame. `locked` rises on the cycle after the synchronised rising edge that closes the second consecutive SCK-free frame with an equal, supported period. A single such frame is not enough.
- R3: A period of 64, 128, 256, 512 or 1024 cycles locks with `sck_mult` = 1 (32 bit-clocks per frame) and `max_width` = 16.
- R4: A period of 96, 192, 384 or 768 cycles locks with `sck_mult` = 2 (48 per frame) and `max_width` = 24.
- R5: A period of exactly 1152 cycles locks with `sck_mult` = 3 (72 per frame) and `max_width` = 24.
- R6: Any other period count never produces lock. `sck_mult` and `max_width` stay 0.
- R7: Any synchronised SCK edge (rising or falling) clears `locked` on the next cycle and sets `ext_mode`. While `ext_mode` is 1, `bclk_en` pulses once for each synchronised SCK rising edge.
- R8: A closing frame whose period differs from the previous one drops `locked`. That frame then counts as the first of a new pair.
- R9: While locked, `bclk_en` pulses every period/multiple cycles, exactly multiple times per frame, and never on two adjacent cycles. The divider phase restarts at each synchronised LRCK rising edge.
- R10: `ext_mode` returns to 0 when a frame closes that contained no SCK edge. `locked` and `ext_mode` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck_in | input | 1 | Word-select line, asynchronous |
| sck_in | input | 1 | Serial bit-clock line, asynchronous, may be idle |
| locked | output | 1 | Internal bit-clock mode is active |
| ext_mode | output | 1 | External bit clock is being followed |
| sck_mult | output | 2 | 0 none, 1 ×32, 2 ×48, 3 ×72 of the sample rate |
| max_width | output | 5 | Maximum data word width in bits (16 or 24), 0 when unlocked |
| bclk_en | output | 1 | One-cycle bit-clock strobe |

## Verification
The bench drives periods from each supported family, the single ×72 ratio, and a period near a valid one (200). A design that accepted near-miss counts, or mapped 384 to the ×32 family, would report the wrong multiple or width. It checks that one quiet frame after reset or after a period change does not lock; an off-by-one frame counter would lock a frame early. It then starts SCK mid-lock and stops it again. A design that kept generating internal strobes, or never left external mode, would show up as a miscounted `bclk_en` over a frame. Every cycle, all outputs are compared against a behavioural model.

// File: rtl/bclk_det_pkg.sv
package bclk_det_pkg;
  typedef enum logic [1:0] {
    MULT_NONE = 2'd0,
    MULT_X32  = 2'd1,
    MULT_X48  = 2'd2,
    MULT_X72  = 2'd3
  } sck_mult_e;

  localparam int unsigned MAX_DIV = 32;
  localparam int unsigned DIV_W   = $clog2(MAX_DIV + 1);
  localparam int unsigned WID_W   = 5;
endpackage

// File: rtl/line_sync.sv
module line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl  = s2_q;
  assign prev = s3_q;
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lr_rise,
  input  logic             sck_any,
  output logic             frame_done,
  output logic             frame_quiet,
  output logic [CNT_W-1:0] period
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             started_q, started_d;
  logic             noisy_q, noisy_d;

  always_comb begin
    cnt_d     = cnt_q;
    started_d = started_q;
    noisy_d   = noisy_q | sck_any;
    if (lr_rise) begin
      cnt_d     = '0;
      started_d = 1'b1;
      noisy_d   = sck_any;
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
      noisy_q   <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
      noisy_q   <= noisy_d;
    end
  end

  assign frame_done  = lr_rise & started_q;
  assign frame_quiet = ~noisy_q;
  assign period      = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  // R2
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lr_rise |=> (cnt_q == '0 && started_q));
endmodule

// File: rtl/ratio_classify.sv
module ratio_classify
  import bclk_det_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic [CNT_W-1:0] period,
  output logic             ok,
  output logic [1:0]       mult,
  output logic [WID_W-1:0] width,
  output logic [DIV_W-1:0] div
);
  always_comb begin
    ok    = 1'b1;
    mult  = MULT_X32;
    width = WID_W'(16);
    div   = '0;
    case (period)
      CNT_W'(64):   div = DIV_W'(2);
      CNT_W'(128):  div = DIV_W'(4);
      CNT_W'(256):  div = DIV_W'(8);
      CNT_W'(512):  div = DIV_W'(16);
      CNT_W'(1024): div = DIV_W'(32);
      CNT_W'(96):   begin mult = MULT_X48; width = WID_W'(24); div = DIV_W'(2);  end
      CNT_W'(192):  begin mult = MULT_X48; width = WID_W'(24); div = DIV_W'(4);  end
      CNT_W'(384):  begin mult = MULT_X48; width = WID_W'(24); div = DIV_W'(8);  end
      CNT_W'(768):  begin mult = MULT_X48; width = WID_W'(24); div = DIV_W'(16); end
      CNT_W'(1152): begin mult = MULT_X72; width = WID_W'(24); div = DIV_W'(16); end
      default: begin
        ok    = 1'b0;
        mult  = MULT_NONE;
        width = '0;
      end
    endcase
  end
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
  import bclk_det_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             lr_rise,
  input  logic [DIV_W-1:0] div,
  output logic             pulse
);
  logic [DIV_W-1:0] phase_q, phase_d;
  logic             wrap;

  assign wrap  = (phase_q == div - 1'b1);
  assign pulse = run & wrap;

  always_comb begin
    if (!run || lr_rise || wrap) phase_d = '0;
    else                         phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // R9
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
endmodule

// File: rtl/bclk_ratio_detect.sv
module bclk_ratio_detect
  import bclk_det_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       lrck_in,
  input  logic       sck_in,
  output logic       locked,
  output logic       ext_mode,
  output logic [1:0] sck_mult,
  output logic [4:0] max_width,
  output logic       bclk_en
);
  logic lr_lvl, lr_prev, sk_lvl, sk_prev;
  logic lr_rise, sck_rise, sck_any;
  logic frame_done, frame_quiet;
  logic [CNT_W-1:0] period;
  logic cls_ok;
  logic [1:0]       cls_mult;
  logic [WID_W-1:0] cls_width;
  logic [DIV_W-1:0] cls_div;
  logic gen_pulse;

  logic             lock_q, lock_d, ext_q, ext_d;
  logic [1:0]       run_q, run_d, mult_q, mult_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic [WID_W-1:0] width_q, width_d;
  logic [DIV_W-1:0] div_q, div_d;

  line_sync u_lr_sync (.clk(mclk), .rst_n(rst_n), .din(lrck_in), .lvl(lr_lvl), .prev(lr_prev));
  line_sync u_sk_sync (.clk(mclk), .rst_n(rst_n), .din(sck_in),  .lvl(sk_lvl), .prev(sk_prev));

  assign lr_rise  = lr_lvl & ~lr_prev;
  assign sck_rise = sk_lvl & ~sk_prev;
  assign sck_any  = sk_lvl ^ sk_prev;

  period_counter #(.CNT_W(CNT_W)) u_count (
    .clk(mclk), .rst_n(rst_n), .lr_rise(lr_rise), .sck_any(sck_any),
    .frame_done(frame_done), .frame_quiet(frame_quiet), .period(period));

  ratio_classify #(.CNT_W(CNT_W)) u_class (
    .period(period), .ok(cls_ok), .mult(cls_mult), .width(cls_width), .div(cls_div));

  bclk_gen u_gen (
    .clk(mclk), .rst_n(rst_n), .run(lock_q), .lr_rise(lr_rise),
    .div(div_q), .pulse(gen_pulse));

  always_comb begin
    lock_d  = lock_q;
    run_d   = run_q;
    last_d  = last_q;
    ext_d   = ext_q;
    mult_d  = mult_q;
    width_d = width_q;
    div_d   = div_q;
    if (frame_done) begin
      last_d = period;
      if (!frame_quiet || !cls_ok) begin
        run_d  = 2'd0;
        lock_d = 1'b0;
      end else if (run_q != 2'd0 && period == last_q) begin
        run_d   = 2'd2;
        lock_d  = 1'b1;
        mult_d  = cls_mult;
        width_d = cls_width;
        div_d   = cls_div;
      end else begin
        run_d  = 2'd1;
        lock_d = 1'b0;
      end
      if (frame_quiet) ext_d = 1'b0;
    end
    if (sck_any) begin
      run_d  = 2'd0;
      lock_d = 1'b0;
      ext_d  = 1'b1;
    end
  end

  always_ff @(posedge mclk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      run_q   <= 2'd0;
      last_q  <= '0;
      ext_q   <= 1'b0;
      mult_q  <= MULT_NONE;
      width_q <= '0;
      div_q   <= '0;
    end else begin
      lock_q  <= lock_d;
      run_q   <= run_d;
      last_q  <= last_d;
      ext_q   <= ext_d;
      mult_q  <= mult_d;
      width_q <= width_d;
      div_q   <= div_d;
    end
  end

  assign locked    = lock_q;
  assign ext_mode  = ext_q;
  assign sck_mult  = lock_q ? mult_q : MULT_NONE;
  assign max_width = lock_q ? width_q : '0;
  assign bclk_en   = ext_q ? sck_rise : gen_pulse;

  // R7
  sck_drop_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    sck_any |=> (!locked && ext_mode));
  // R10
  mode_excl_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    !(locked && ext_mode));
  // R2
  lock_on_frame_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_done && frame_quiet));
  // R3
  width_pair_chk: assert property (@(posedge mclk) disable iff (!rst_n)
    locked |-> ((sck_mult == MULT_X32 && max_width == 5'd16) ||
                (sck_mult != MULT_X32 && sck_mult != MULT_NONE && max_width == 5'd24)));
endmodule

// File: tb/test_bclk_ratio_detect.sv
module test_bclk_ratio_detect;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lrck = 1'b0;
  logic sck = 1'b0;
  logic locked, ext_mode, bclk_en;
  logic [1:0] sck_mult;
  logic [4:0] max_width;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bclk_ratio_detect i_bclk_ratio_detect (
    .mclk(clk), .rst_n(rst_n), .lrck_in(lrck), .sck_in(sck),
    .locked(locked), .ext_mode(ext_mode), .sck_mult(sck_mult),
    .max_width(max_width), .bclk_en(bclk_en));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit is_pow2(input int x);
    return x > 0 && (x & (x - 1)) == 0;
  endfunction

  task automatic classify(input int per, output bit ok, output int mu, output int wd, output int dv);
    ok = 0; mu = 0; wd = 0; dv = 0;
    if (per % 32 == 0 && is_pow2(per / 32) && per / 32 >= 2 && per / 32 <= 32) begin
      ok = 1; mu = 1; wd = 16; dv = per / 32;
    end else if (per % 48 == 0 && is_pow2(per / 48) && per / 48 >= 2 && per / 48 <= 16) begin
      ok = 1; mu = 2; wd = 24; dv = per / 48;
    end else if (per == 1152) begin
      ok = 1; mu = 3; wd = 24; dv = 16;
    end
  endtask

  // behavioural reference
  bit l1, l2, l3, c1, c2, c3;
  int mcnt, mlast, mrun, mph, mdiv, mmult, mwidth;
  bit mstarted, mnoisy, mlocked, mext;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1 = 0; l2 = 0; l3 = 0; c1 = 0; c2 = 0; c3 = 0;
      mcnt = 0; mlast = 0; mrun = 0; mph = 0; mdiv = 0; mmult = 0; mwidth = 0;
      mstarted = 0; mnoisy = 0; mlocked = 0; mext = 0;
    end else begin
      bit rise, sany, fd, quiet, ok, nlock;
      int per, mu, wd, dv, nrun;
      rise = l2 && !l3;
      sany = c2 != c3;
      fd = rise && mstarted;
      per = (mcnt == 4095) ? 4095 : mcnt + 1;
      quiet = !mnoisy;
      classify(per, ok, mu, wd, dv);
      if (!mlocked || rise || mph == mdiv - 1) mph = 0; else mph++;
      nlock = mlocked; nrun = mrun;
      if (fd) begin
        if (!quiet || !ok) begin nrun = 0; nlock = 0; end
        else if (mrun != 0 && per == mlast) begin
          nrun = 2; nlock = 1; mmult = mu; mwidth = wd; mdiv = dv;
        end else begin nrun = 1; nlock = 0; end
        mlast = per;
        if (quiet) mext = 0;
      end
      if (sany) begin nrun = 0; nlock = 0; mext = 1; end
      if (rise) begin mcnt = 0; mstarted = 1; mnoisy = sany; end
      else begin
        if (mcnt != 4095) mcnt++;
        mnoisy = mnoisy || sany;
      end
      mlocked = nlock; mrun = nrun;
      l3 = l2; l2 = l1; l1 = lrck;
      c3 = c2; c2 = c1; c1 = sck;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit eb;
      eb = mext ? (c2 && !c3) : (mlocked && mph == mdiv - 1);
      chk("R2 locked", int'(locked), int'(mlocked));
      chk("R10 ext_mode", int'(ext_mode), int'(mext));
      chk("R3 sck_mult", int'(sck_mult), mlocked ? mmult : 0);
      chk("R4 max_width", int'(max_width), mlocked ? mwidth : 0);
      chk("R9 bclk_en", int'(bclk_en), int'(eb));
      if (bclk_en) pulses++;
    end
  end

  task automatic frames(input int n, input int cnt, input int sck_half);
    for (int f = 0; f < cnt; f++) begin
      for (int i = 0; i < n; i++) begin
        @(negedge clk);
        lrck = (i < n / 2);
        if (sck_half > 0 && i % sck_half == 0) sck = !sck;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs in reset
    chk("R1 locked", int'(locked), 0);
    chk("R1 sck_mult", int'(sck_mult), 0);
    chk("R1 max_width", int'(max_width), 0);
    chk("R1 bclk_en", int'(bclk_en), 0);
    chk("R1 ext_mode", int'(ext_mode), 0);
    rst_n = 1'b1;
    frames(256, 2, 0);
    chk("R2 one quiet frame not enough", int'(locked), 0);
    frames(256, 1, 0);
    chk("R2 locked after two frames", int'(locked), 1);
    chk("R3 mult for 256", int'(sck_mult), 1);
    chk("R3 width for 256", int'(max_width), 16);
    pulses = 0;
    frames(256, 1, 0);
    chk("R9 strobes per frame x32", pulses, 32);
    frames(384, 2, 0);
    chk("R8 period change drops lock", int'(locked), 0);
    frames(384, 1, 0);
    chk("R4 mult for 384", int'(sck_mult), 2);
    chk("R4 width for 384", int'(max_width), 24);
    pulses = 0;
    frames(384, 1, 0);
    chk("R9 strobes per frame x48", pulses, 48);
    frames(1152, 3, 0);
    chk("R5 mult for 1152", int'(sck_mult), 3);
    chk("R5 width for 1152", int'(max_width), 24);
    frames(200, 4, 0);
    chk("R6 no lock for 200", int'(locked), 0);
    chk("R6 mult none for 200", int'(sck_mult), 0);
    frames(64, 3, 0);
    chk("R3 lock for 64", int'(locked), 1);
    frames(64, 1, 2);
    chk("R7 sck drops lock", int'(locked), 0);
    chk("R7 ext mode set", int'(ext_mode), 1);
    pulses = 0;
    frames(64, 1, 2);
    chk("R7 strobes follow sck", pulses, 16);
    frames(64, 2, 0);
    chk("R10 ext mode cleared", int'(ext_mode), 0);
    frames(64, 1, 0);
    chk("R2 relock after quiet frames", int'(locked), 1);
    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule